// File: doc/BRIEF.md
# I2C SCL Baud Rate Generator

This block derives the bit timing of an I2C master from the system clock. A 7-bit baud word carries two fields: a 4-bit linear factor M and a 3-bit exponent N. The block divides the system clock by (M+1) × 2^(N+1) to produce a one-cycle sub-bit tick. The master controller uses that tick to step through the low and high halves of SCL and to time changes on SDA. Ten sub-bit ticks make one SCL period, so the SCL frequency is the system clock divided by 10 × (M+1) × 2^(N+1).

Internally the block is a chain of three counters. A power-of-two prescaler of length 2^(N+1) feeds a linear counter of length M+1. Each terminal count of the linear counter is one sub-bit tick, and a phase counter numbers the ticks within the SCL period. Loading a new baud word clears every counter, so the new rate always starts from a clean phase. While the controller is disabled the counters hold at zero and no ticks come out.

Top module: `i2c_scl_baudgen`

## Requirements
- R1: The baud word `baud_wdata` is captured on a rising clock edge where `baud_wr` is high. Bits [6:3] are M and bits [2:0] are N.
- R2: While running, `bit_tick` is a single-cycle pulse. Consecutive pulses are exactly D = (M+1) × 2^(N+1) clock cycles apart.
- R3: After a restart, the first `bit_tick` comes D cycles after the clearing edge, in cycle D-1 counted from zero. A restart is a write, or `enable` rising.
- R4: `bit_phase` starts at 0 and advances by one on the edge after each `bit_tick`. It wraps from 9 to 0 and never exceeds 9.
- R5: `scl_period_end` is high exactly in the cycle of the tick taken while `bit_phase` is 9. One SCL period is therefore 10 × D cycles.
- R6: A write restarts the generator. No `bit_tick` is emitted in the write cycle, and all counters are zero in the following cycle. This holds whether or not the block is enabled.
- R7: While `enable` is low, `bit_tick` and `scl_period_end` stay low. `bit_phase` reads 0 from the cycle after `enable` falls.
- R8: After reset the baud word is 0 (M=0, N=0, D=2), `bit_phase` is 0 and no tick is emitted.
- R9: The slowest setting (M=15, N=7) gives an SCL period of 40960 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low holds every counter at zero |
| baud_wr | input | 1 | Load strobe for the baud word; also restarts the counters |
| baud_wdata | input | 7 | Baud word: M in bits [6:3], N in bits [2:0] |
| bit_tick | output | 1 | Sub-bit timing pulse, ten per SCL period |
| bit_phase | output | 4 | Index 0..9 of the current sub-bit slot |
| scl_period_end | output | 1 | High with the tick that closes an SCL period |

## Verification
The hardest conditions to reach are a restart that lands part-way through a prescaler count, and the longest divide chain. A restart in mid-count leaves stale counter values that must not leak into the next interval. The bench stops a slow setting at a cycle where all three counters are non-zero, then either rewrites the baud word or drops `enable`. It then times the very next tick against the arithmetic expectation. Every M value is swept against the low exponents, and the top exponents are covered at their corners. The slowest setting is timed over a full 40960-cycle SCL period.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;
   // Interval in system clocks between two sub-bit ticks for given fields.
   function automatic int unsigned tick_interval(input int unsigned m_val,
                                                 input int unsigned n_val);
      return (m_val + 1) * (2 << n_val);
   endfunction
endpackage

// File: rtl/i2c_baud_field_reg.sv
module i2c_baud_field_reg #(
   parameter int          M_W        = 4,
   parameter int          N_W        = 3,
   parameter int unsigned RESET_BAUD = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [M_W+N_W-1:0] wdata,
   output logic [M_W-1:0]     m_field,
   output logic [N_W-1:0]     n_field
);
   localparam int BW = M_W + N_W;
   logic [BW-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= BW'(RESET_BAUD);
      else if (wr) word_q <= wdata;
   end

   // M sits above N; the divider stages decode them separately.
   assign m_field = word_q[BW-1:N_W];
   assign n_field = word_q[N_W-1:0];
endmodule

// File: rtl/i2c_pow2_prescaler.sv
module i2c_pow2_prescaler #(
   parameter int N_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           run,
   input  logic [N_W-1:0] exp_sel,
   output logic           pre_pulse
);
   localparam int CNT_W = 1 << N_W;   // wide enough for 2^(2^N_W) states

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   span;
   logic [CNT_W:0]   span_m1;
   logic [CNT_W-1:0] limit;
   logic             at_limit;

   assign span     = (CNT_W+1)'(2) << exp_sel;
   assign span_m1  = span - 1'b1;
   assign limit    = span_m1[CNT_W-1:0];
   assign at_limit = (cnt_q == limit);
   assign pre_pulse = run && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear)    cnt_q <= '0;
      else if (run)      cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/i2c_linear_divider.sv
module i2c_linear_divider #(
   parameter int M_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           in_pulse,
   input  logic [M_W-1:0] m_field,
   output logic           out_pulse
);
   logic [M_W-1:0] cnt_q;
   logic           at_term;

   assign at_term   = (cnt_q == m_field);
   assign out_pulse = in_pulse && at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (clear)     cnt_q <= '0;
      else if (in_pulse)  cnt_q <= at_term ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/i2c_phase_sequencer.sv
module i2c_phase_sequencer #(
   parameter int TICKS = 10,
   parameter int PH_W  = $clog2(TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            tick,
   output logic [PH_W-1:0] phase,
   output logic            last_slot
);
   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] phase_nx;

   generate
      if (TICKS == (1 << PH_W)) begin : g_pow2_wrap
         // Natural binary rollover gives the wrap for free.
         assign last_slot = &phase_q;
         assign phase_nx  = phase_q + 1'b1;
      end else begin : g_cmp_wrap
         assign last_slot = (phase_q == PH_W'(TICKS - 1));
         assign phase_nx  = last_slot ? '0 : phase_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase_q <= '0;
      else if (clear) phase_q <= '0;
      else if (tick)  phase_q <= phase_nx;
   end

   assign phase = phase_q;
endmodule

// File: rtl/i2c_scl_baudgen.sv
module i2c_scl_baudgen #(
   parameter int          M_W           = 4,
   parameter int          N_W           = 3,
   parameter int          TICKS_PER_BIT = 10,
   parameter int unsigned RESET_BAUD    = 0,
   localparam int         BW            = M_W + N_W,
   localparam int         PH_W          = $clog2(TICKS_PER_BIT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            baud_wr,
   input  logic [BW-1:0]   baud_wdata,
   output logic            bit_tick,
   output logic [PH_W-1:0] bit_phase,
   output logic            scl_period_end
);
   generate
      if (M_W < 1 || M_W > 8) begin : g_bad_m
         $error("M_W out of range");
      end
      if (N_W < 1 || N_W > 4) begin : g_bad_n
         $error("N_W out of range");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be at least 2");
      end
      if (RESET_BAUD >= (1 << BW)) begin : g_bad_reset
         $error("RESET_BAUD does not fit the baud word");
      end
   endgenerate

   logic [M_W-1:0] m_field;
   logic [N_W-1:0] n_field;
   logic           restart;
   logic           run;
   logic           pre_pulse;
   logic           sub_tick;
   logic           last_slot;

   assign restart = baud_wr || !enable;
   assign run     = enable && !baud_wr;

   i2c_baud_field_reg #(.M_W(M_W), .N_W(N_W), .RESET_BAUD(RESET_BAUD)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(baud_wr), .wdata(baud_wdata),
      .m_field(m_field), .n_field(n_field)
   );

   i2c_pow2_prescaler #(.N_W(N_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clear(restart), .run(run),
      .exp_sel(n_field), .pre_pulse(pre_pulse)
   );

   i2c_linear_divider #(.M_W(M_W)) u_lin (
      .clk(clk), .rst_n(rst_n), .clear(restart), .in_pulse(pre_pulse),
      .m_field(m_field), .out_pulse(sub_tick)
   );

   i2c_phase_sequencer #(.TICKS(TICKS_PER_BIT), .PH_W(PH_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .clear(restart), .tick(sub_tick),
      .phase(bit_phase), .last_slot(last_slot)
   );

   assign bit_tick       = sub_tick;
   assign scl_period_end = sub_tick && last_slot;
endmodule

// File: rtl/i2c_scl_baudgen_chk.sv
module i2c_scl_baudgen_chk #(
   parameter int          M_W           = 4,
   parameter int          N_W           = 3,
   parameter int          TICKS_PER_BIT = 10,
   parameter int unsigned RESET_BAUD    = 0,
   parameter int          PH_W          = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enable,
   input logic            baud_wr,
   input logic [M_W+N_W-1:0] baud_wdata,
   input logic            bit_tick,
   input logic [PH_W-1:0] bit_phase,
   input logic            scl_period_end
);
   import i2c_baud_pkg::*;

   logic [M_W+N_W-1:0] shadow_q;
   int unsigned        gap_q;
   int unsigned        span;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       shadow_q <= (M_W+N_W)'(RESET_BAUD);
      else if (baud_wr) shadow_q <= baud_wdata;
   end

   assign span = tick_interval(int'(shadow_q[M_W+N_W-1:N_W]), int'(shadow_q[N_W-1:0]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   gap_q <= 0;
      else if (baud_wr || !enable)  gap_q <= 0;
      else if (bit_tick)            gap_q <= 0;
      else                          gap_q <= gap_q + 1;
   end

   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> (gap_q == span - 1));
   p_no_missed_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < span);
   p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_phase < PH_W'(TICKS_PER_BIT));
   p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !baud_wr && bit_tick && !scl_period_end)
         |=> (bit_phase == PH_W'($past(bit_phase) + 1'b1)));
   p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !baud_wr && !bit_tick) |=> $stable(bit_phase));
   p_period_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scl_period_end |-> (bit_tick && bit_phase == PH_W'(TICKS_PER_BIT - 1)));
   p_wr_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      baud_wr |-> !bit_tick);
   p_wr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      baud_wr |=> (bit_phase == '0));
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!bit_tick && !scl_period_end));
   p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (bit_phase == '0));
endmodule

bind i2c_scl_baudgen i2c_scl_baudgen_chk #(
   .M_W(M_W), .N_W(N_W), .TICKS_PER_BIT(TICKS_PER_BIT),
   .RESET_BAUD(RESET_BAUD), .PH_W(PH_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .baud_wr(baud_wr),
   .baud_wdata(baud_wdata), .bit_tick(bit_tick), .bit_phase(bit_phase),
   .scl_period_end(scl_period_end)
);

// File: tb/tb_i2c_scl_baudgen.sv
module tb_i2c_scl_baudgen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       baud_wr = 1'b0;
   logic [6:0] baud_wdata = '0;
   logic       bit_tick;
   logic [3:0] bit_phase;
   logic       scl_period_end;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_scl_baudgen dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .baud_wr(baud_wr),
      .baud_wdata(baud_wdata), .bit_tick(bit_tick), .bit_phase(bit_phase),
      .scl_period_end(scl_period_end)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Starts at a negedge where the block is running from cleared counters.
   // Cycle c is checked at c+1ns after that negedge; leaves at a negedge.
   task automatic measure(input int m, input int n, input int cycles, input string req);
      int d = (m + 1) * (2 << n);
      bit bad = 1'b0;
      for (int c = 0; c < cycles; c++) begin
         int et = ((c + 1) % d == 0) ? 1 : 0;
         int ep = (c / d) % 10;
         int em = (et == 1 && ((c + 1) / d) % 10 == 0) ? 1 : 0;
         #1;
         if (!bad && (int'(bit_tick) != et || int'(bit_phase) != ep || int'(scl_period_end) != em)) begin
            bad = 1'b1;
            $display("FAIL %s m=%0d n=%0d cycle %0d: actual tick/phase/end %0d/%0d/%0d expected %0d/%0d/%0d",
                     req, m, n, c, bit_tick, bit_phase, scl_period_end, et, ep, em);
         end
         @(negedge clk);
      end
      tests++;
      if (bad) fails++;
   endtask

   // Writes M/N in one cycle; checks that no tick appears in it (R6).
   task automatic write_baud(input int m, input int n);
      @(negedge clk);
      baud_wr = 1'b1;
      baud_wdata = {m[3:0], n[2:0]};
      #1 check("R6", "tick in write cycle", int'(bit_tick), 0);
      @(negedge clk);
      baud_wr = 1'b0;
   endtask

   initial begin
      #1;
      check("R8", "tick in reset", int'(bit_tick), 0);
      check("R8", "phase in reset", int'(bit_phase), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: disabled out of reset, nothing moves
      repeat (5) begin
         #1 check("R7", "tick while off", int'(bit_tick), 0);
         @(negedge clk);
      end
      // R8/R3: default word gives D=2 from the enabling edge
      enable = 1'b1;
      measure(0, 0, 40, "R8");

      // R1/R2/R4/R5: every M with the low exponents, one SCL period each
      for (int n = 0; n < 4; n++)
         for (int m = 0; m < 16; m++) begin
            write_baud(m, n);
            measure(m, n, 10 * (m + 1) * (2 << n), "R1");
         end
      // R2: high exponents at M=0
      for (int n = 4; n < 8; n++) begin
         write_baud(0, n);
         measure(0, n, 10 * (2 << n), "R2");
      end

      // R6: rewrite while all three counters hold non-zero values (D=16)
      write_baud(3, 1);
      measure(3, 1, 37, "R6");
      write_baud(1, 0);
      measure(1, 0, 80, "R6");

      // R7: drop enable mid-period, D=6, phase 3 at cycle 23
      write_baud(2, 0);
      measure(2, 0, 23, "R7");
      enable = 1'b0;
      #1 check("R7", "tick on falling enable", int'(bit_tick), 0);
      @(negedge clk);
      repeat (15) begin
         #1 check("R7", "phase while off", int'(bit_phase), 0);
         check("R7", "end marker while off", int'(scl_period_end), 0);
         @(negedge clk);
      end
      enable = 1'b1;
      measure(2, 0, 60, "R7");

      // R6/R1: word written while disabled takes effect at enable
      enable = 1'b0;
      write_baud(5, 2);
      repeat (4) begin
         #1 check("R6", "tick after write while off", int'(bit_tick), 0);
         @(negedge clk);
      end
      enable = 1'b1;
      measure(5, 2, 480, "R6");

      // R9: slowest setting, full SCL period of 40960 clocks
      write_baud(15, 7);
      measure(15, 7, 40960, "R9");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule